// File: doc/BRIEF.md
# Segment Descriptor Rights Query Unit

This unit answers one query at a time about the attribute bits of a segment descriptor. A request carries a 16-bit selector, the current privilege level, and the processor mode: protected enabled, virtual-8086 and long mode. It also carries the operand width and the base and limit of the global and the local descriptor tables. The unit screens the selector first. An unusable selector fails at once. Otherwise the unit reads the descriptor's upper 32-bit word through a single-outstanding read port.

Once the word returns, the unit checks that the descriptor type is acceptable in the current mode. It also checks that the descriptor is visible at both the current privilege level and the requested privilege level. A conforming code segment skips the visibility check. On success the unit packs the attribute fields into a fixed rights layout. It then raises a success flag and writes the result. A request made outside protected operation produces an undefined-instruction indication instead.

Top module: `seg_rights_probe`

## Requirements
- R1: When `prot_en` is 0 or `v86` is 1 at start, the query finishes with `done`=1, `undef`=1 and `ok`=0. No read is issued and `rights` keeps its previous value.
- R2: A selector with table bit (bit 2) = 0 and index (bits 15:3) = 0 fails (`ok`=0, `undef`=0) with no read. The same index with bit 2 = 1 is not treated as null.
- R3: With index i, the query fails with no read when i*8+7 exceeds the limit of the selected table (bit 2: 0 global, 1 local). It goes ahead when i*8+7 equals the limit.
- R4: A query that passes R1 to R3 reads address base+i*8+4 of the selected table. `rd_req` and `rd_addr` stay steady until `rd_vld`, and no read occurs otherwise.
- R5: The returned word is decoded as follows: type in bits 11:8, S in bit 12, DPL in bits 14:13. Any type with S=1 is acceptable. With S=0 outside long mode, only types 1, 2, 3, 4, 5, 9, B and C are acceptable.
- R6: With S=0 in long mode (`long_md`=1), only types 2, 9, B and C are acceptable.
- R7: Unless the descriptor is conforming code (S=1, type bits 3 and 2 both 1), the query fails when CPL > DPL or RPL (selector bits 1:0) > DPL.
- R8: With `wide`=1, a successful result copies word bits 15:8 and 23:20 into the same positions of `rights`. All other bits of `rights` are 0.
- R9: With `wide`=0, a successful result copies word bits 15:8 only. Bits 31:16 and 7:0 of `rights` are 0.
- R10: `done` is a one-cycle pulse. `rights_we` pulses with `done` only on success. `ok`, `undef` and `rights` change only in the `done` cycle, and a failed query leaves `rights` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a query; ignored while a read is pending |
| sel | input | 16 | Segment selector |
| cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protected operation enabled |
| v86 | input | 1 | Virtual-8086 operation |
| long_md | input | 1 | Long mode type table selector |
| wide | input | 1 | 1: 32-bit result, 0: 16-bit result |
| gtab_base | input | AW | Global table base address |
| gtab_lim | input | LW | Global table limit |
| ltab_base | input | AW | Local table base address |
| ltab_lim | input | LW | Local table limit |
| rd_req | output | 1 | Read request, held until response |
| rd_addr | output | AW | Read byte address |
| rd_vld | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| done | output | 1 | Query finished pulse |
| ok | output | 1 | Success flag |
| undef | output | 1 | Undefined-instruction indication |
| rights_we | output | 1 | Result write pulse |
| rights | output | 32 | Formatted rights word |

## Verification
The assertions assume the following about the inputs. `rd_vld` is asserted only while `rd_req` is high. `start` is not raised while a read is pending. The table inputs stay steady for the length of a query. The bench drives `start` only between queries and returns exactly one response, after 0 to 3 idle cycles, for each observed request. It changes table bases, limits and mode bits only before raising `start`, so every random query stays inside these assumptions.

// File: rtl/seg_rights_probe.sv
module seg_rights_probe #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   sel,
  input  logic [1:0]    cpl,
  input  logic          prot_en,
  input  logic          v86,
  input  logic          long_md,
  input  logic          wide,
  input  logic [AW-1:0] gtab_base,
  input  logic [LW-1:0] gtab_lim,
  input  logic [AW-1:0] ltab_base,
  input  logic [LW-1:0] ltab_lim,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_vld,
  input  logic [31:0]   rd_data,
  output logic          done,
  output logic          ok,
  output logic          undef,
  output logic          rights_we,
  output logic [31:0]   rights
);
  localparam logic [15:0] SYS_OK_PM = 16'h1A3E;
  localparam logic [15:0] SYS_OK_LM = 16'h1A04;

  typedef enum logic {S_IDLE, S_RD} st_t;
  st_t st;

  logic [1:0] cpl_q, rpl_q;
  logic       lm_q, wide_q;

  wire        ti       = sel[2];
  wire [12:0] idx      = sel[15:3];
  wire [LW:0] end_off  = (LW+1)'({idx, 3'b111});
  wire [LW:0] lim      = {1'b0, ti ? ltab_lim : gtab_lim};
  wire        is_null  = !ti && idx == 13'd0;
  wire        past_lim = end_off > lim;
  wire        trap     = !prot_en || v86;
  wire [AW-1:0] addr_n = (ti ? ltab_base : gtab_base) + AW'({idx, 3'b100});

  wire [3:0]  ty      = rd_data[11:8];
  wire        s_f     = rd_data[12];
  wire [1:0]  dpl     = rd_data[14:13];
  wire        ty_ok   = s_f || (lm_q ? SYS_OK_LM[ty] : SYS_OK_PM[ty]);
  wire        conf    = s_f && ty[3] && ty[2];
  wire        priv_ok = conf || (cpl_q <= dpl && rpl_q <= dpl);
  wire        pass    = ty_ok && priv_ok;
  wire [31:0] keep    = wide_q ? 32'h00F0_FF00 : 32'h0000_FF00;

  assign rd_req = (st == S_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cpl_q     <= '0;
      rpl_q     <= '0;
      lm_q      <= 1'b0;
      wide_q    <= 1'b0;
      rd_addr   <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
      undef     <= 1'b0;
      rights_we <= 1'b0;
      rights    <= '0;
    end else begin
      done      <= 1'b0;
      rights_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cpl_q  <= cpl;
          rpl_q  <= sel[1:0];
          lm_q   <= long_md;
          wide_q <= wide;
          if (trap) begin
            done  <= 1'b1;
            undef <= 1'b1;
            ok    <= 1'b0;
          end else if (is_null || past_lim) begin
            done  <= 1'b1;
            undef <= 1'b0;
            ok    <= 1'b0;
          end else begin
            rd_addr <= addr_n;
            st      <= S_RD;
          end
        end
        S_RD: if (rd_vld) begin
          done  <= 1'b1;
          undef <= 1'b0;
          ok    <= pass;
          if (pass) begin
            rights    <= rd_data & keep;
            rights_we <= 1'b1;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_rights_probe_chk.sv
module seg_rights_probe_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req,
  input logic          rd_vld,
  input logic [AW-1:0] rd_addr,
  input logic          done,
  input logic          ok,
  input logic          undef,
  input logic          rights_we,
  input logic [31:0]   rights
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_vld |=> rd_req && $stable(rd_addr));
  p_req_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !done);
  p_undef_fails_r1: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !ok);
  p_we_needs_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rights_we |-> done && ok);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rights) && $stable(ok) && $stable(undef));
  p_layout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rights[31:24] == 8'h0 && rights[19:16] == 4'h0 && rights[7:0] == 8'h0);
endmodule

bind seg_rights_probe seg_rights_probe_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_vld(rd_vld),
  .rd_addr(rd_addr), .done(done), .ok(ok), .undef(undef),
  .rights_we(rights_we), .rights(rights)
);

// File: tb/sim_seg_rights_probe.sv
module sim_seg_rights_probe;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] sel = 0;
  logic [1:0]  cpl = 0;
  logic        prot_en = 0, v86 = 0, long_md = 0, wide = 0;
  logic [31:0] gtab_base = 0, gtab_lim = 0, ltab_base = 0, ltab_lim = 0;
  logic        rd_req, rd_vld = 0;
  logic [31:0] rd_addr, rd_data = 0;
  logic        done, ok, undef, rights_we;
  logic [31:0] rights;

  int n_chk = 0, n_bad = 0;
  logic [31:0] last_r = 0;

  always #5 clk = ~clk;

  seg_rights_probe u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .cpl(cpl),
    .prot_en(prot_en), .v86(v86), .long_md(long_md), .wide(wide),
    .gtab_base(gtab_base), .gtab_lim(gtab_lim), .ltab_base(ltab_base),
    .ltab_lim(ltab_lim), .rd_req(rd_req), .rd_addr(rd_addr), .rd_vld(rd_vld),
    .rd_data(rd_data), .done(done), .ok(ok), .undef(undef),
    .rights_we(rights_we), .rights(rights)
  );

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit sys_ok(input logic [3:0] t, input bit lm);
    if (lm) return (t == 4'h2 || t == 4'h9 || t == 4'hB || t == 4'hC);
    return (t inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h9, 4'hB, 4'hC});
  endfunction

  task automatic run_q(input logic [15:0] s, input logic [1:0] c, input bit pe_i,
                       input bit v_i, input bit lm_i, input bit w_i,
                       input logic [31:0] desc, input int lat);
    bit e_ud, e_null, e_lim, e_rd, e_ty, e_pv, e_ok, saw_rd, saw_done, saw_we;
    logic [12:0] ix;
    logic [31:0] lim, e_addr, e_r;
    string why;
    int cnt, l;
    ix     = s[15:3];
    e_ud   = !pe_i || v_i;
    lim    = s[2] ? ltab_lim : gtab_lim;
    e_null = !s[2] && ix == 0;
    e_lim  = {16'd0, ix, 3'b111} > lim;
    e_rd   = !e_ud && !e_null && !e_lim;
    e_addr = (s[2] ? ltab_base : gtab_base) + {16'd0, ix, 3'b100};
    e_ty   = desc[12] || sys_ok(desc[11:8], lm_i);
    e_pv   = (desc[12] && desc[11] && desc[10]) ||
             (c <= desc[14:13] && s[1:0] <= desc[14:13]);
    e_ok   = e_rd && e_ty && e_pv;
    e_r    = !e_ok ? last_r :
             w_i ? {8'h0, desc[23:20], 4'h0, desc[15:8], 8'h0} : {16'h0, desc[15:8], 8'h0};
    why    = e_ud ? "R1" : e_null ? "R2" : e_lim ? "R3" :
             !e_ty ? (lm_i ? "R6" : "R5") : !e_pv ? "R7" : (w_i ? "R8" : "R9");

    sel = s; cpl = c; prot_en = pe_i; v86 = v_i; long_md = lm_i; wide = w_i;
    start = 1;
    @(negedge clk);
    start = 0;
    saw_rd = 0; saw_done = 0; saw_we = 0; cnt = 0; l = lat;
    while (!saw_done && cnt < 40) begin
      if (done) begin
        saw_done = 1;
        saw_we   = rights_we;
      end else begin
        if (rd_req) begin
          if (!saw_rd) chk(rd_addr == e_addr, "R4 read address", rd_addr, e_addr);
          saw_rd = 1;
          if (l == 0) begin rd_vld = 1; rd_data = desc; end
          else l--;
        end
        @(negedge clk);
        rd_vld = 0;
        cnt++;
      end
    end
    chk(saw_done, "R10 done seen", 32'(saw_done), 1);
    chk(saw_rd == e_rd, {why, " R4 read issued"}, 32'(saw_rd), 32'(e_rd));
    chk(undef == e_ud, {why, " R1 undef"}, 32'(undef), 32'(e_ud));
    chk(ok == e_ok, {why, " ok flag"}, 32'(ok), 32'(e_ok));
    chk(saw_we == e_ok, {why, " R10 write pulse"}, 32'(saw_we), 32'(e_ok));
    chk(rights == e_r, {why, " rights"}, rights, e_r);
    @(negedge clk);
    chk(!done && !rights_we, "R10 single pulse", {30'd0, done, rights_we}, 0);
    chk(rights == e_r && ok == e_ok, "R10 hold", rights, e_r);
    last_r = e_r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !ok && !undef && !rights_we && !rd_req && rights == 0,
        "R10 reset state", rights, 0);
    rst_n = 1;
    @(negedge clk);

    gtab_base = 32'h1000; gtab_lim = 32'h1F;
    ltab_base = 32'h8000; ltab_lim = 32'hFF;
    // R1: outside protected operation and in virtual-8086
    run_q(16'h0018, 0, 0, 0, 0, 1, 32'h0000_9A00, 0);
    run_q(16'h0018, 0, 1, 1, 0, 1, 32'h0000_9A00, 0);
    // R2: null global, local index 0 is not null
    run_q(16'h0003, 0, 1, 0, 0, 1, 32'h00F0_9200, 0);
    run_q(16'h0004, 0, 1, 0, 0, 1, 32'h00F0_9200, 1);
    // R3: limit edge (index 3 ends at 0x1F, index 4 beyond)
    run_q(16'h0018, 0, 1, 0, 0, 1, 32'h00A0_9200, 2);
    run_q(16'h0020, 0, 1, 0, 0, 1, 32'h00A0_9200, 0);
    // R7: conforming bypass vs nonconforming, RPL check
    run_q(16'h0008, 3, 1, 0, 0, 1, 32'h0000_9E00, 0);
    run_q(16'h0008, 3, 1, 0, 0, 1, 32'h0000_9A00, 0);
    run_q(16'h000B, 0, 1, 0, 0, 1, 32'h0000_B200, 3);
    // R5/R6: type 4 legacy ok, long mode rejected; type 2 and C in long mode
    run_q(16'h0010, 0, 1, 0, 0, 1, 32'h0000_8400, 0);
    run_q(16'h0010, 0, 1, 0, 1, 1, 32'h0000_8400, 0);
    run_q(16'h0010, 0, 1, 0, 1, 1, 32'h0000_8200, 1);
    run_q(16'h0010, 0, 1, 0, 1, 1, 32'h0000_EC00, 1);
    run_q(16'h0010, 0, 1, 0, 0, 1, 32'h0000_8800, 1);
    // R8/R9: same all-ones word, wide and narrow
    run_q(16'h0008, 0, 1, 0, 0, 1, 32'hFFFF_FFFF, 0);
    run_q(16'h0008, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, 2);

    for (int i = 0; i < 600; i++) begin
      logic [15:0] s;
      gtab_base = $urandom & 32'hFFFF_FFF8;
      ltab_base = $urandom & 32'hFFFF_FFF8;
      gtab_lim  = $urandom % 32'h200;
      ltab_lim  = $urandom % 32'h200;
      s = 16'($urandom);
      if ($urandom % 2) s[15:8] = 8'h0;
      if ($urandom % 8 == 0) s[15:3] = 13'h0;
      run_q(s, 2'($urandom), ($urandom % 8) != 0, ($urandom % 10) == 0,
            1'($urandom), 1'($urandom), $urandom, int'($urandom % 4));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule